// File: doc/BRIEF.md
# Four-Queue Gather Buffer with Width-Matched Read Port

This block holds four equal-depth FIFO queues. Each queue has its own 10-bit write port, and the four ports work independently of each other. A single read port drains one queue at a time. A 2-bit select input names that queue. The read word is 10, 20 or 40 bits wide. In the wider settings, successive entries of the chosen queue are packed into one word, with the oldest entry in the lowest lane.

Every queue reports four flags: full, empty, almost-full and almost-empty. The thresholds for the two "almost" flags are set by offsets. Two composite flags repeat the full and empty state of the queue that the read select currently names. Each queue also has its own partial reset, which clears only that queue.

The read width, the read timing style (registered or fall-through) and both flag offsets are captured while the master reset is held. They stay fixed until the next master reset. All ports share one clock.

Top module: `qmux4_fifo`

## Requirements
- R1: Each queue q accepts a 10-bit entry from `wr_data[10q+9:10q]` in any cycle where `wr_en[q]` is high and the queue is not full. A write to one queue never changes the contents or flags of another queue.
- R2: An accepted read takes entries only from the queue named by `rd_sel` (0 to 3). Entries come out in the order they were written.
- R3: Flags are derived from the number of entries, n, in a queue:
  - `q_empty` is high when n = 0.
  - `q_full` is high when n = DEPTH.
  - `q_afull` is high when n >= DEPTH - af_off.
  - `q_aempty` is high when n <= ae_off.
- R4: A write to a full queue is dropped. The queue's contents and pointers are unchanged.
- R5: `sel_full` and `sel_empty` equal the full and empty flags of the queue named by `rd_sel` in the same cycle.
- R6: A high `q_prst[q]` empties queue q in the next cycle. Its pointers return to the first location, so the next entry written is the next entry read. Other queues and all captured settings are untouched.
- R7: Read timing is set by `cfg_fwft`:
  - With `cfg_fwft` = 0 (standard), `rd_data` is registered. It is 0 after master reset, takes the new word in the cycle after an accepted read, and otherwise holds.
  - With `cfg_fwft` = 1 (fall-through), `rd_data` shows the head word of the selected queue without any read, and `rd_en` only removes it.
- R8: `cfg_width`, `cfg_fwft`, `cfg_af_off` and `cfg_ae_off` are sampled only while `rst_n` is low. Changes made while `rst_n` is high have no effect.
- R9: A read is accepted only if the selected queue holds at least one beat of entries. Otherwise the read is ignored: no entry is removed, and a standard-mode `rd_data` holds its value.
- R10: `cfg_width` selects the beat size:
  - Code 0 gives x10 (1 entry per beat), code 1 gives x20 (2 entries) and code 2 gives x40 (4 entries). Code 3 acts as x10.
  - Entry k of a beat, counting from the oldest, sits in bits [10k+9:10k].
  - Unused upper bits read as 0.
- R11: Master reset (`rst_n` low) empties all four queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Master reset, active low, synchronous; captures settings |
| cfg_width | input | 2 | Read width code (0 x10, 1 x20, 2 x40) |
| cfg_fwft | input | 1 | 1 selects fall-through read timing |
| cfg_af_off | input | log2(DEPTH) | Almost-full offset |
| cfg_ae_off | input | log2(DEPTH) | Almost-empty offset |
| wr_en | input | 4 | Per-queue write enable |
| wr_data | input | 40 | Four 10-bit write lanes, queue q in bits [10q+9:10q] |
| q_prst | input | 4 | Per-queue partial reset |
| rd_sel | input | 2 | Queue chosen for reading |
| rd_en | input | 1 | Read request |
| rd_data | output | 40 | Packed read word |
| q_full | output | 4 | Per-queue full |
| q_empty | output | 4 | Per-queue empty |
| q_afull | output | 4 | Per-queue almost-full |
| q_aempty | output | 4 | Per-queue almost-empty |
| sel_full | output | 1 | Full flag of selected queue |
| sel_empty | output | 1 | Empty flag of selected queue |

## Verification
The properties assume that a partial reset and a read of the same queue never occur in the same cycle. They also assume that the settings are stable during the reset cycles that capture them. The stimulus meets both assumptions: each bench task drives a single operation per cycle, and every task starts and ends at a falling edge. Partial resets are applied only in cycles that have no read. A new set of settings is always applied together with a fresh master reset.

// File: rtl/qmux_pkg.sv
package qmux_pkg;
   localparam int unsigned NQ = 4;
   localparam int unsigned LANES = 4;

   typedef enum logic [1:0] {
      BW_X10 = 2'd0,
      BW_X20 = 2'd1,
      BW_X40 = 2'd2
   } bw_e;

   // entries consumed per accepted read
   function automatic logic [2:0] beat_of(input logic [1:0] code);
      case (code)
         BW_X20:  beat_of = 3'd2;
         BW_X40:  beat_of = 3'd4;
         default: beat_of = 3'd1;
      endcase
   endfunction
endpackage

// File: rtl/qmux_queue.sv
module qmux_queue #(
   parameter int DW    = 10,
   parameter int DEPTH = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic                      push,
   input  logic [DW-1:0]             din,
   input  logic [2:0]                pop_n,
   output logic [$clog2(DEPTH):0]    cnt,
   output logic [qmux_pkg::LANES*DW-1:0] heads
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push;

   assign do_push = push && (cnt != CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         rptr <= rptr + AW'(pop_n);
         cnt  <= cnt + CW'(do_push) - CW'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   for (genvar k = 0; k < qmux_pkg::LANES; k++) begin : g_head
      assign heads[k*DW +: DW] = mem[rptr + AW'(k)];
   end
endmodule

// File: rtl/qmux_flags.sv
module qmux_flags #(
   parameter int DEPTH = 16
) (
   input  logic [$clog2(DEPTH):0]   cnt,
   input  logic [$clog2(DEPTH)-1:0] af_off,
   input  logic [$clog2(DEPTH)-1:0] ae_off,
   output logic                     full,
   output logic                     empty,
   output logic                     afull,
   output logic                     aempty
);
   localparam int CW = $clog2(DEPTH) + 1;

   assign full   = (cnt == CW'(DEPTH));
   assign empty  = (cnt == '0);
   assign afull  = (cnt >= (CW'(DEPTH) - {1'b0, af_off}));
   assign aempty = (cnt <= {1'b0, ae_off});
endmodule

// File: rtl/qmux_pack.sv
module qmux_pack #(
   parameter int DW = 10
) (
   input  logic [qmux_pkg::LANES*DW-1:0] heads,
   input  logic [1:0]                    code,
   output logic [qmux_pkg::LANES*DW-1:0] word
);
   logic [2:0] beat;
   assign beat = qmux_pkg::beat_of(code);

   for (genvar k = 0; k < qmux_pkg::LANES; k++) begin : g_lane
      assign word[k*DW +: DW] = (beat > 3'(k)) ? heads[k*DW +: DW] : '0;
   end
endmodule

// File: rtl/qmux4_fifo.sv
module qmux4_fifo #(
   parameter int DW    = 10,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 cfg_width,
   input  logic                       cfg_fwft,
   input  logic [$clog2(DEPTH)-1:0]   cfg_af_off,
   input  logic [$clog2(DEPTH)-1:0]   cfg_ae_off,
   input  logic [3:0]                 wr_en,
   input  logic [4*DW-1:0]            wr_data,
   input  logic [3:0]                 q_prst,
   input  logic [1:0]                 rd_sel,
   input  logic                       rd_en,
   output logic [4*DW-1:0]            rd_data,
   output logic [3:0]                 q_full,
   output logic [3:0]                 q_empty,
   output logic [3:0]                 q_afull,
   output logic [3:0]                 q_aempty,
   output logic                       sel_full,
   output logic                       sel_empty
);
   import qmux_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam int OW = LANES * DW;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("qmux4_fifo: DEPTH must be a power of two and at least 4");
   end
   if (DW < 1) begin : g_bad_dw
      $error("qmux4_fifo: DW must be positive");
   end

   // settings captured during master reset
   logic [1:0]    bw_q;
   logic          fwft_q;
   logic [AW-1:0] af_q, ae_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bw_q   <= cfg_width;
         fwft_q <= cfg_fwft;
         af_q   <= cfg_af_off;
         ae_q   <= cfg_ae_off;
      end
   end

   logic [2:0]    beat;
   logic [CW-1:0] q_cnt  [NQ];
   logic [OW-1:0] q_head [NQ];
   logic          rd_go;
   logic [OW-1:0] packed_w;
   logic [OW-1:0] rd_data_q;

   assign beat  = beat_of(bw_q);
   assign rd_go = rd_en && (q_cnt[rd_sel] >= CW'(beat));

   for (genvar g = 0; g < NQ; g++) begin : g_q
      logic [2:0] pop_n;
      assign pop_n = (rd_go && rd_sel == 2'(g)) ? beat : 3'd0;

      qmux_queue #(.DW(DW), .DEPTH(DEPTH)) u_queue (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (q_prst[g]),
         .push  (wr_en[g]),
         .din   (wr_data[g*DW +: DW]),
         .pop_n (pop_n),
         .cnt   (q_cnt[g]),
         .heads (q_head[g])
      );

      qmux_flags #(.DEPTH(DEPTH)) u_flags (
         .cnt    (q_cnt[g]),
         .af_off (af_q),
         .ae_off (ae_q),
         .full   (q_full[g]),
         .empty  (q_empty[g]),
         .afull  (q_afull[g]),
         .aempty (q_aempty[g])
      );
   end

   assign sel_full  = q_full[rd_sel];
   assign sel_empty = q_empty[rd_sel];

   qmux_pack #(.DW(DW)) u_pack (
      .heads (q_head[rd_sel]),
      .code  (bw_q),
      .word  (packed_w)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data_q <= '0;
      else if (rd_go) rd_data_q <= packed_w;
   end

   assign rd_data = fwft_q ? packed_w : rd_data_q;
endmodule

// File: rtl/qmux4_fifo_chk.sv
module qmux4_fifo_chk #(
   parameter int DW = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    wr_en,
   input logic [3:0]    q_prst,
   input logic [1:0]    rd_sel,
   input logic          rd_en,
   input logic          fwft_q,
   input logic [4*DW-1:0] rd_data,
   input logic [3:0]    q_full,
   input logic [3:0]    q_empty,
   input logic [3:0]    q_afull
);
   for (genvar i = 0; i < 4; i++) begin : g_p
      // R1: an accepted write leaves the queue non-empty
      a_r1_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en[i] && !q_full[i] && !q_prst[i]) |=> !q_empty[i]);

      // R4: with no read or clear, a full queue stays full whatever is written
      a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (q_full[i] && !q_prst[i] && !(rd_en && rd_sel == 2'(i))) |=> q_full[i]);

      // R3: full implies almost-full
      a_r3_full_afull: assert property (@(posedge clk) disable iff (!rst_n)
         q_full[i] |-> q_afull[i]);

      // R6: partial reset empties the queue next cycle
      a_r6_prst_empty: assert property (@(posedge clk) disable iff (!rst_n)
         q_prst[i] |=> q_empty[i]);
   end

   // R9: standard-mode read of an empty queue leaves the output alone
   a_r9_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwft_q && rd_en && q_empty[rd_sel]) |=> $stable(rd_data));
endmodule

bind qmux4_fifo qmux4_fifo_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .q_prst  (q_prst),
   .rd_sel  (rd_sel),
   .rd_en   (rd_en),
   .fwft_q  (fwft_q),
   .rd_data (rd_data),
   .q_full  (q_full),
   .q_empty (q_empty),
   .q_afull (q_afull)
);

// File: tb/sim_qmux4_fifo.sv
`timescale 1ns/1ps
module sim_qmux4_fifo;
   localparam int DW = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_width = 2'd0;
   logic        cfg_fwft = 1'b0;
   logic [3:0]  cfg_af_off = 4'd2;
   logic [3:0]  cfg_ae_off = 4'd1;
   logic [3:0]  wr_en = '0;
   logic [39:0] wr_data = '0;
   logic [3:0]  q_prst = '0;
   logic [1:0]  rd_sel = '0;
   logic        rd_en = 1'b0;
   logic [39:0] rd_data;
   logic [3:0]  q_full, q_empty, q_afull, q_aempty;
   logic        sel_full, sel_empty;

   always #5 clk = ~clk;

   qmux4_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

   int n_tot = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int beat_m = 1;
   int mq [4][$];
   logic [39:0] sb [$];

   task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
      n_tot++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   endtask

   task automatic reset_cfg(input logic [1:0] w, input logic f);
      cfg_width = w;
      cfg_fwft = f;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      beat_m = (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
      for (int q = 0; q < 4; q++) mq[q].delete();
   endtask

   task automatic wr(input logic [3:0] m, input int base);
      for (int i = 0; i < 4; i++) begin
         wr_data[i*10 +: 10] = 10'(base + i);
         if (m[i] && mq[i].size() < DEPTH) mq[i].push_back(base + i);
      end
      wr_en = m;
      @(negedge clk);
      wr_en = '0;
   endtask

   // standard-mode read: driver pushes expectation, checker pops
   task automatic rd(input int q, input string tag);
      logic [39:0] prev;
      logic [39:0] e;
      bit acc;
      prev = rd_data;
      e = '0;
      acc = (mq[q].size() >= beat_m);
      if (acc) begin
         for (int k = 0; k < beat_m; k++) e[k*10 +: 10] = 10'(mq[q].pop_front());
         sb.push_back(e);
      end
      rd_sel = 2'(q);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (acc) chk(tag, rd_data, sb.pop_front());
      else chk(tag, rd_data, prev);
   endtask

   function automatic logic [39:0] peek(input int q);
      logic [39:0] e;
      e = '0;
      for (int k = 0; k < beat_m; k++) e[k*10 +: 10] = 10'(mq[q][k]);
      return e;
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_tot++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(negedge clk);
      reset_cfg(2'd0, 1'b0);
      // R11 reset state
      chk("R11 empty", 40'(q_empty), 40'hF);
      chk("R11 full", 40'(q_full), 40'h0);
      chk("R3 aempty reset", 40'(q_aempty), 40'hF);
      chk("R3 afull reset", 40'(q_afull), 40'h0);
      chk("R7 rd_data reset", rd_data, 40'h0);

      // R1 independent writes into q0 and q2
      for (int n = 0; n < 3; n++) wr(4'b0101, 10 * n);
      chk("R1 empty pattern", 40'(q_empty), 40'hA);
      chk("R3 aempty n=3", 40'(q_aempty), 40'hA);

      // R2 / R10 x10 order from q2, then q0
      for (int n = 0; n < 3; n++) rd(2, "R2 q2 order");
      rd(0, "R2 q0 untouched");

      // R3 fill q1
      for (int n = 0; n < 13; n++) wr(4'b0010, 100 + 4 * n);
      chk("R3 afull n=13", 40'(q_afull[1]), 40'h0);
      wr(4'b0010, 500);
      chk("R3 afull n=14", 40'(q_afull[1]), 40'h1);
      wr(4'b0010, 510);
      wr(4'b0010, 520);
      chk("R3 full n=16", 40'(q_full[1]), 40'h1);

      // R5 composite flags follow rd_sel
      rd_sel = 2'd1;
      #1 chk("R5 sel_full q1", 40'(sel_full), 40'h1);
      rd_sel = 2'd0;
      #1 chk("R5 sel_full q0", 40'(sel_full), 40'h0);
      chk("R5 sel_empty q0", 40'(sel_empty), 40'h0);
      rd_sel = 2'd3;
      #1 chk("R5 sel_empty q3", 40'(sel_empty), 40'h1);
      @(negedge clk);

      // R4 write to full q1 dropped, then drain with order check
      wr(4'b0010, 900);
      for (int n = 0; n < 16; n++) rd(1, "R4 q1 drain");
      chk("R4 q1 empty after 16", 40'(q_empty[1]), 40'h1);
      rd(1, "R9 empty read holds");

      // R6 partial reset q0 (2 entries) leaves q3 alone
      wr(4'b1000, 300);
      wr(4'b1000, 310);
      q_prst = 4'b0001;
      @(negedge clk);
      q_prst = '0;
      mq[0].delete();
      chk("R6 q0 empty", 40'(q_empty[0]), 40'h1);
      chk("R6 q3 kept", 40'(q_empty[3]), 40'h0);
      wr(4'b0001, 77);
      rd(0, "R6 first after prst");

      // R8 settings changed outside reset are ignored
      cfg_width = 2'd2;
      cfg_fwft = 1'b1;
      @(negedge clk);
      rd(3, "R8 width kept");
      rd(3, "R8 width kept 2");

      // R7 fall-through, R10 x20
      reset_cfg(2'd1, 1'b1);
      chk("R11 empty again", 40'(q_empty), 40'hF);
      for (int n = 0; n < 3; n++) wr(4'b1000, 40 + 4 * n);
      rd_sel = 2'd3;
      #1 chk("R7 fwft head x20", rd_data, peek(3));
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      void'(mq[3].pop_front());
      void'(mq[3].pop_front());
      // one entry left: read must be refused (R9)
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R9 x20 single kept", 40'(q_empty[3]), 40'h0);
      wr(4'b1000, 60);
      chk("R10 x20 packing", rd_data, peek(3));

      // R10 x40 standard
      reset_cfg(2'd2, 1'b0);
      for (int n = 0; n < 3; n++) wr(4'b0010, 200 + 4 * n);
      rd(1, "R9 x40 three refused");
      wr(4'b0010, 220);
      rd(1, "R10 x40 packing");
      chk("R10 x40 drained", 40'(q_empty[1]), 40'h1);

      finish_run();
   end
endmodule